// File: doc/BRIEF.md
# Tally character sequencer

This block serves one memory reference made through a tally-style indirect word. Such a word keeps a running pointer in memory. Its top 18 bits are a word address, the next 12 bits are a tally count and the low 6 bits are a tag. The tag's low bits can hold a character position inside the addressed word. The block accepts the indirect word, the memory address the word was fetched from, and a 3-bit operation code. From these it forms the effective address and reads the data word at that address. It then picks out the selected 6-bit or 9-bit character, or the whole word. Last, it writes the updated indirect word back to the address it came from.

Because the pointer, the count and the character position all sit in one memory word, each access moves the pointer one step. Strings are therefore walked strictly in sequence; a character cannot be reached at random. The block returns its result right-justified and zero-extended to 36 bits. In the same cycle as the write-back it pulses a run-out flag when the updated tally has reached zero.

Bit numbering is big-endian. Character 0 is the most significant character of the data word. A word holds six 6-bit characters or four 9-bit characters.

Top module: `tally_seq`

## Requirements
- R1: Operation code 0 (word forward) uses the current address as the effective address. It writes back the word with the address plus 1 and the tally minus 1, and leaves the tag unchanged. The result is the whole data word.
- R2: Operation code 1 (word backward) first takes the address minus 1, modulo 2^18, and uses it as the effective address. It writes back that address with the tally plus 1, modulo 2^12, and leaves the tag unchanged. The result is the whole data word.
- R3: Operation codes 2 and 4 select a 6-bit character. The position is tag bits [2:0]. Position p is data bits [35-6p -: 6], returned right-justified and zero-extended. Positions 6 and 7 return zero.
- R4: Operation codes 3 and 5 select a 9-bit character. The position is tag bits [1:0]. Position p is data bits [35-9p -: 9], returned right-justified and zero-extended.
- R5: The sequencing codes 2 and 3 use the current address as the effective address and decrement the tally. Each one also advances the position field by one and keeps the upper tag bits. For code 2, a position of 5 or more wraps to 0 and the address is incremented. For code 3, position 3 wraps to 0 and the address is incremented.
- R6: The non-updating codes 4 and 5 (characters) and 6 and 7 (whole word) use the current address. They write the indirect word back unchanged and never raise run-out.
- R7: For codes 0 to 3, `runout_o` is high for exactly the write-back cycle when the updated tally is zero. It is never high without `done_o`.
- R8: After a start, the transfers follow a fixed order. First the block drives one cycle of `mem_rd_o` with the effective address. It then waits for `mem_rvalid_i` in any later cycle. Next comes one cycle of `mem_wr_o` to `ind_ptr_i` with the updated word, and `done_o` is high in that cycle. `sel_pos_o` shows the character position in use before any advance, and is 0 for the whole-word codes.
- R9: A `start_i` that arrives while `busy_o` is high is ignored. It does not change the operation in progress.
- R10: While reset is held, and right after it, `busy_o`, `mem_rd_o`, `mem_wr_o`, `done_o` and `runout_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one operation (taken only while idle) |
| op_i | input | 3 | Operation code |
| ind_word_i | input | 36 | Indirect word: address, tally, tag |
| ind_ptr_i | input | 18 | Address the indirect word is written back to |
| mem_rdata_i | input | 36 | Read data from memory |
| mem_rvalid_i | input | 1 | Read data valid |
| busy_o | output | 1 | An operation is in progress |
| mem_rd_o | output | 1 | Read request at `mem_addr_o` |
| mem_wr_o | output | 1 | Write request at `mem_addr_o` |
| mem_addr_o | output | 18 | Effective address on a read, pointer address on a write |
| mem_wdata_o | output | 36 | Updated indirect word |
| done_o | output | 1 | Operation completes in this cycle |
| runout_o | output | 1 | Updated tally is zero |
| result_o | output | 36 | Extracted character or word, held until the next operation |
| sel_pos_o | output | 3 | Character position in use |

## Verification
A wrong update of the position, tally or address shows up as a wrong value on `mem_wdata_o` during the write-back cycle, three cycles after start when memory answers at once. A wrong effective address appears on `mem_addr_o` in the read cycle, one cycle after start. A wrong state in the control sequence shows as a read or write strobe that lasts too long, comes out of order or is missing. A missed or extra run-out pulse is visible in the write-back cycle itself.

// File: rtl/tally_pkg.sv
package tally_pkg;
    localparam int WORD_W  = 36;
    localparam int ADDR_W  = 18;
    localparam int TALLY_W = 12;
    localparam int TAG_W   = WORD_W - ADDR_W - TALLY_W;
    localparam int C6_W    = 6;
    localparam int C9_W    = 9;
    localparam int POS_W   = 3;

    typedef enum logic [2:0] {
        OP_WORD_FWD = 3'd0,
        OP_WORD_BWD = 3'd1,
        OP_C6_STEP  = 3'd2,
        OP_C9_STEP  = 3'd3,
        OP_C6_PEEK  = 3'd4,
        OP_C9_PEEK  = 3'd5,
        OP_W_PEEK_A = 3'd6,
        OP_W_PEEK_B = 3'd7
    } tally_op_e;

    typedef enum logic [1:0] {
        CW_WORD = 2'd0,
        CW_SIX  = 2'd1,
        CW_NINE = 2'd2
    } char_width_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_WRITE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/tally_step.sv
module tally_step
    import tally_pkg::*;
(
    input  tally_op_e          op_i,
    input  logic [WORD_W-1:0]  word_i,
    output logic [ADDR_W-1:0]  eff_o,
    output logic [WORD_W-1:0]  next_word_o,
    output char_width_e        width_o,
    output logic [POS_W-1:0]   pos_o,
    output logic               runout_o
);
    logic [ADDR_W-1:0]  addr_cur, addr_d;
    logic [TALLY_W-1:0] tally_cur, tally_d;
    logic [TAG_W-1:0]   tag_cur, tag_d;
    logic               updates;

    assign addr_cur  = word_i[WORD_W-1 -: ADDR_W];
    assign tally_cur = word_i[TAG_W +: TALLY_W];
    assign tag_cur   = word_i[TAG_W-1:0];

    always_comb begin
        eff_o   = addr_cur;
        addr_d  = addr_cur;
        tally_d = tally_cur;
        tag_d   = tag_cur;
        updates = 1'b0;
        width_o = CW_WORD;
        pos_o   = '0;
        case (op_i)
            OP_WORD_FWD: begin
                addr_d  = addr_cur + ADDR_W'(1);
                tally_d = tally_cur - TALLY_W'(1);
                updates = 1'b1;
            end
            OP_WORD_BWD: begin
                addr_d  = addr_cur - ADDR_W'(1);
                eff_o   = addr_d;
                tally_d = tally_cur + TALLY_W'(1);
                updates = 1'b1;
            end
            OP_C6_STEP: begin
                width_o = CW_SIX;
                pos_o   = tag_cur[2:0];
                tally_d = tally_cur - TALLY_W'(1);
                updates = 1'b1;
                if (tag_cur[2:0] >= 3'd5) begin
                    tag_d  = {tag_cur[TAG_W-1:3], 3'd0};
                    addr_d = addr_cur + ADDR_W'(1);
                end else begin
                    tag_d  = {tag_cur[TAG_W-1:3], 3'(tag_cur[2:0] + 3'd1)};
                end
            end
            OP_C9_STEP: begin
                width_o = CW_NINE;
                pos_o   = {1'b0, tag_cur[1:0]};
                tally_d = tally_cur - TALLY_W'(1);
                updates = 1'b1;
                if (tag_cur[1:0] == 2'd3) begin
                    tag_d  = {tag_cur[TAG_W-1:2], 2'd0};
                    addr_d = addr_cur + ADDR_W'(1);
                end else begin
                    tag_d  = {tag_cur[TAG_W-1:2], 2'(tag_cur[1:0] + 2'd1)};
                end
            end
            OP_C6_PEEK: begin
                width_o = CW_SIX;
                pos_o   = tag_cur[2:0];
            end
            OP_C9_PEEK: begin
                width_o = CW_NINE;
                pos_o   = {1'b0, tag_cur[1:0]};
            end
            default: ;
        endcase
        next_word_o = {addr_d, tally_d, tag_d};
        runout_o    = updates && (tally_d == '0);
    end
endmodule

// File: rtl/tally_char_pick.sv
module tally_char_pick
    import tally_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    input  char_width_e       width_i,
    input  logic [POS_W-1:0]  pos_i,
    output logic [WORD_W-1:0] result_o
);
    localparam int N6 = WORD_W / C6_W;
    localparam int N9 = WORD_W / C9_W;

    logic [C6_W-1:0] slot6 [N6];
    logic [C9_W-1:0] slot9 [N9];

    for (genvar g = 0; g < N6; g++) begin : g_six
        assign slot6[g] = data_i[WORD_W-1-C6_W*g -: C6_W];
    end
    for (genvar g = 0; g < N9; g++) begin : g_nine
        assign slot9[g] = data_i[WORD_W-1-C9_W*g -: C9_W];
    end

    always_comb begin
        result_o = '0;
        case (width_i)
            CW_SIX: begin
                for (int i = 0; i < N6; i++)
                    if (pos_i == POS_W'(i)) result_o = WORD_W'(slot6[i]);
            end
            CW_NINE: begin
                for (int i = 0; i < N9; i++)
                    if (pos_i == POS_W'(i)) result_o = WORD_W'(slot9[i]);
            end
            default: result_o = data_i;
        endcase
    end
endmodule

// File: rtl/tally_seq.sv
module tally_seq
    import tally_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2:0]          op_i,
    input  logic [WORD_W-1:0]   ind_word_i,
    input  logic [ADDR_W-1:0]   ind_ptr_i,
    input  logic [WORD_W-1:0]   mem_rdata_i,
    input  logic                mem_rvalid_i,
    output logic                busy_o,
    output logic                mem_rd_o,
    output logic                mem_wr_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [WORD_W-1:0]   mem_wdata_o,
    output logic                done_o,
    output logic                runout_o,
    output logic [WORD_W-1:0]   result_o,
    output logic [POS_W-1:0]    sel_pos_o
);
    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] eff;
        logic [WORD_W-1:0] nword;
        char_width_e       width;
        logic [POS_W-1:0]  pos;
        logic              run;
        logic [WORD_W-1:0] result;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [ADDR_W-1:0] step_eff;
    logic [WORD_W-1:0] step_word;
    char_width_e       step_width;
    logic [POS_W-1:0]  step_pos;
    logic              step_run;
    logic [WORD_W-1:0] pick_val;

    tally_step u_step (
        .op_i        (tally_op_e'(op_i)),
        .word_i      (ind_word_i),
        .eff_o       (step_eff),
        .next_word_o (step_word),
        .width_o     (step_width),
        .pos_o       (step_pos),
        .runout_o    (step_run)
    );

    tally_char_pick u_pick (
        .data_i   (mem_rdata_i),
        .width_i  (r_q.width),
        .pos_i    (r_q.pos),
        .result_o (pick_val)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: if (start_i) begin
                r_d.st    = ST_READ;
                r_d.ptr   = ind_ptr_i;
                r_d.eff   = step_eff;
                r_d.nword = step_word;
                r_d.width = step_width;
                r_d.pos   = step_pos;
                r_d.run   = step_run;
            end
            ST_READ: r_d.st = ST_WAIT;
            ST_WAIT: if (mem_rvalid_i) begin
                r_d.result = pick_val;
                r_d.st     = ST_WRITE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o      = r_q.st != ST_IDLE;
    assign mem_rd_o    = r_q.st == ST_READ;
    assign mem_wr_o    = r_q.st == ST_WRITE;
    assign mem_addr_o  = (r_q.st == ST_WRITE) ? r_q.ptr : r_q.eff;
    assign mem_wdata_o = r_q.nword;
    assign done_o      = r_q.st == ST_WRITE;
    assign runout_o    = (r_q.st == ST_WRITE) && r_q.run;
    assign result_o    = r_q.result;
    assign sel_pos_o   = r_q.pos;

    a_r8_read_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o && busy_o);
    a_r8_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> !mem_wr_o && !busy_o);
    a_r8_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));
    a_r7_runout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        runout_o |-> done_o && mem_wr_o);
    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(mem_wdata_o));
endmodule

// File: tb/tally_seq_tb.sv
module tally_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [35:0] ind_word_i = '0;
    logic [17:0] ind_ptr_i = '0;
    logic [35:0] mem_rdata_i = '0;
    logic        mem_rvalid_i = 1'b0;
    logic        busy_o, mem_rd_o, mem_wr_o, done_o, runout_o;
    logic [17:0] mem_addr_o;
    logic [35:0] mem_wdata_o, result_o;
    logic [2:0]  sel_pos_o;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tally_seq dut_i (.*);

    typedef struct packed {
        logic [2:0]  op;
        logic [35:0] w;
        logic [35:0] data;
        logic [17:0] eff;
        logic [35:0] nw;
        logic [35:0] res;
        logic        run;
        logic [2:0]  pos;
        logic [1:0]  lat;
        logic        poke;
        logic [3:0]  req;
    } vec_t;

    localparam logic [35:0] D6 = 36'o010203040506;
    localparam logic [35:0] D9 = 36'o101202303404;
    localparam int NV = 14;

    // field order: op, word, data, eff, written word, result, runout, pos, latency, poke, requirement
    localparam vec_t VECS [NV] = '{
        // R1 forward word
        '{3'd0, {18'o1000, 12'd3, 6'o17}, 36'o777000111222, 18'o1000, {18'o1001, 12'd2, 6'o17}, 36'o777000111222, 1'b0, 3'd0, 2'd0, 1'b0, 4'd1},
        // R7 forward word reaching zero tally
        '{3'd0, {18'o2000, 12'd1, 6'o00}, D6, 18'o2000, {18'o2001, 12'd0, 6'o00}, D6, 1'b1, 3'd0, 2'd1, 1'b0, 4'd7},
        // R2 backward word
        '{3'd1, {18'o3000, 12'd7, 6'o05}, D9, 18'o2777, {18'o2777, 12'd8, 6'o05}, D9, 1'b0, 3'd0, 2'd2, 1'b0, 4'd2},
        // R2/R7 backward from address 0 with tally wrap to 0
        '{3'd1, {18'o0, 12'hFFF, 6'o00}, D6, 18'o777777, {18'o777777, 12'd0, 6'o00}, D6, 1'b1, 3'd0, 2'd0, 1'b0, 4'd7},
        // R3 six-bit position 0
        '{3'd2, {18'o400, 12'd10, 6'o70}, D6, 18'o400, {18'o400, 12'd9, 6'o71}, 36'o01, 1'b0, 3'd0, 2'd1, 1'b0, 4'd3},
        // R5 six-bit position 3, with a start while busy (R9)
        '{3'd2, {18'o400, 12'd9, 6'o23}, D6, 18'o400, {18'o400, 12'd8, 6'o24}, 36'o04, 1'b0, 3'd3, 2'd2, 1'b1, 4'd5},
        // R5 six-bit wrap from position 5
        '{3'd2, {18'o400, 12'd2, 6'o55}, D6, 18'o400, {18'o401, 12'd1, 6'o50}, 36'o06, 1'b0, 3'd5, 2'd0, 1'b0, 4'd5},
        // R4 nine-bit position 1
        '{3'd3, {18'o500, 12'd4, 6'o41}, D9, 18'o500, {18'o500, 12'd3, 6'o42}, 36'o202, 1'b0, 3'd1, 2'd1, 1'b0, 4'd4},
        // R7 nine-bit wrap from 3 with run-out
        '{3'd3, {18'o500, 12'd1, 6'o07}, D9, 18'o500, {18'o501, 12'd0, 6'o04}, 36'o404, 1'b1, 3'd3, 2'd0, 1'b0, 4'd7},
        // R6 six-bit peek, zero tally gives no run-out
        '{3'd4, {18'o600, 12'd0, 6'o02}, D6, 18'o600, {18'o600, 12'd0, 6'o02}, 36'o03, 1'b0, 3'd2, 2'd0, 1'b0, 4'd6},
        // R6 nine-bit peek
        '{3'd5, {18'o601, 12'd5, 6'o30}, D9, 18'o601, {18'o601, 12'd5, 6'o30}, 36'o101, 1'b0, 3'd0, 2'd1, 1'b0, 4'd6},
        // R6 whole-word peek, code 6
        '{3'd6, {18'o700, 12'd5, 6'o12}, 36'o123456701234, 18'o700, {18'o700, 12'd5, 6'o12}, 36'o123456701234, 1'b0, 3'd0, 2'd0, 1'b0, 4'd6},
        // R3 invalid six-bit position 6 gives zero and wraps
        '{3'd2, {18'o400, 12'd3, 6'o06}, D6, 18'o400, {18'o401, 12'd2, 6'o00}, 36'o0, 1'b0, 3'd6, 2'd0, 1'b0, 4'd3},
        // R6 whole-word peek, code 7
        '{3'd7, {18'o701, 12'd0, 6'o77}, 36'o1, 18'o701, {18'o701, 12'd0, 6'o77}, 36'o1, 1'b0, 3'd0, 2'd1, 1'b0, 4'd6}
    };

    task automatic chk(input string req, input string what, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%o exp=%o", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic run_vec(input vec_t v, input logic [17:0] ptr);
        string rq;
        rq = $sformatf("R%0d", v.req);
        @(negedge clk);
        start_i = 1'b1; op_i = v.op; ind_word_i = v.w; ind_ptr_i = ptr;
        @(negedge clk);
        start_i = 1'b0;
        chk(rq, "R8 read strobe", 36'(mem_rd_o), 36'd1);
        chk(rq, "effective address", 36'(mem_addr_o), 36'(v.eff));
        chk(rq, "R8 busy", 36'(busy_o), 36'd1);
        @(negedge clk);
        chk(rq, "R8 read single", 36'(mem_rd_o), 36'd0);
        if (v.poke) begin
            start_i = 1'b1; op_i = 3'd1; ind_word_i = 36'o777777777777; ind_ptr_i = 18'o55;
        end
        for (int k = 0; k < int'(v.lat); k++) begin
            @(negedge clk);
            start_i = 1'b0;
        end
        start_i = 1'b0;
        mem_rvalid_i = 1'b1; mem_rdata_i = v.data;
        @(negedge clk);
        mem_rvalid_i = 1'b0; mem_rdata_i = '0;
        chk(rq, "R8 write strobe", 36'(mem_wr_o), 36'd1);
        chk(rq, "R8 write address", 36'(mem_addr_o), 36'(ptr));
        chk(rq, "written word", mem_wdata_o, v.nw);
        chk(rq, "R8 done", 36'(done_o), 36'd1);
        chk(rq, "R7 runout", 36'(runout_o), 36'(v.run));
        chk(rq, "result", result_o, v.res);
        chk(rq, "R8 sel_pos", 36'(sel_pos_o), 36'(v.pos));
        @(negedge clk);
        chk(rq, "R7 runout drop", 36'(runout_o), 36'd0);
        chk(rq, "R8 idle after", 36'(busy_o), 36'd0);
        chk(rq, "result held", result_o, v.res);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired act=running exp=finished");
        report();
    end

    initial begin
        // R10 reset state, start held during reset
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "busy", 36'(busy_o), 36'd0);
        chk("R10", "read", 36'(mem_rd_o), 36'd0);
        chk("R10", "write", 36'(mem_wr_o), 36'd0);
        chk("R10", "done", 36'(done_o), 36'd0);
        chk("R10", "runout", 36'(runout_o), 36'd0);
        chk("R10", "result", result_o, 36'd0);
        start_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "busy after release", 36'(busy_o), 36'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 18'(18'o100 + i));

        // R9 back-to-back: a start in the write-back cycle is ignored
        run_vec(VECS[5], 18'o210);
        @(negedge clk);
        start_i = 1'b1; op_i = 3'd0; ind_word_i = {18'o1234, 12'd2, 6'o00}; ind_ptr_i = 18'o300;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        mem_rvalid_i = 1'b1; mem_rdata_i = D6;
        @(negedge clk);
        mem_rvalid_i = 1'b0;
        start_i = 1'b1; op_i = 3'd1; ind_word_i = '0; ind_ptr_i = 18'o1;
        chk("R9", "written word", mem_wdata_o, {18'o1235, 12'd1, 6'o00});
        @(negedge clk);
        start_i = 1'b0;
        chk("R9", "busy after write with start", 36'(busy_o), 36'd0);
        chk("R9", "no new read", 36'(mem_rd_o), 36'd0);

        repeat (2) @(negedge clk);
        report();
    end
endmodule